// File: doc/BRIEF.md
# Mailbox receive-side register frame

This block is the register frame a receiving agent uses to observe a shared-memory-style mailbox. It holds one 32-bit status word per channel window. The sending side sets bits in these words through a vector of one-cycle set pulses. Through a simple word-addressed register port the receiver reads each window's raw and masked status, clears status bits, and programs a per-window 32-bit mask. The mask is changed only through separate write-1-to-set and write-1-to-clear aliases.

Every status-clear write is also returned to the sender as a vector of one-cycle clear pulses, so both frames stay in step. A level interrupt is raised while any window has a status bit that is not masked. The same activity appears in four combined words that hold one bit per window. A second interrupt output follows the first only when the combined-interrupt enable bit is set.

A message that spans several windows is sent with every window masked except the last. Earlier words then land silently, and the interrupt fires only when the final window is written. The window count is a parameter from 1 to 124, and it can be read back from a configuration word.

Top module: `mbx_rx_frame`

## Requirements
- R1: Window w occupies byte addresses 0x20*w to 0x20*w+0x1F. Raw status reads at offset 0x00, and the port carries the byte address divided by four.
- R2: A read at window offset 0x04 returns the raw status ANDed with the inverse of the mask.
- R3: A write at window offset 0x08 clears exactly the status bits written as 1. In that same cycle, snd_clr_o carries the written word on lanes 32*w to 32*w+31, and all other lanes are 0.
- R4: A set pulse on snd_set_i bit 32*w+b sets status bit b of window w. Status bits hold until cleared. A set and a clear on the same bit in the same cycle leave the bit at 1.
- R5: A write at offset 0x14 sets, and a write at offset 0x18 clears, only the mask bits written as 1. The mask reads at offset 0x10.
- R6: After reset every status bit is 0, every mask bit is 1, the enable bit is 0, and both interrupts are low.
- R7: irq_o is high, from the cycle after the state change, exactly while some window has a nonzero masked status.
- R8: Combined word k at 0xFA0+4*k has bit b set when window 32*k+b has nonzero masked status. Bits for windows that do not exist read 0.
- R9: The enable word at 0xF98 stores only bit 2 and reads 0 in all other bits. comb_irq_o equals irq_o ANDed with that bit.
- R10: The word at 0xF80 reads the window count in bits [6:0] and 0 above.
- R11: Writes to 0x00, 0x04, 0x10, 0x0C, 0x1C, 0xF80, the combined words, or any unmapped address change no state. Reads of the clear and set aliases and of unmapped addresses return 0.
- R12: reg_rdata is loaded on the clock edge where reg_rd_en is high, with the value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_waddr | input | 10 | Word address (byte address bits 11:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd_en |
| snd_set_i | input | NUM_WIN*32 | Set pulses from the sender, lane 32*w+b is window w bit b |
| snd_clr_o | output | NUM_WIN*32 | Clear pulses to the sender, same lane layout |
| irq_o | output | 1 | Any unmasked status bit set |
| comb_irq_o | output | 1 | irq_o gated by the combined-interrupt enable |

## Verification
Directed patterns come first. A set lands on a fully masked window, and the test shows the raw view changes while the masked view and the interrupt do not. A three-window message is then sent with only its last window unmasked, which shows that the interrupt waits for the final word.

Other directed cases target single-bit behaviour. A set and a clear hit the same bit in one cycle. Partial clears and partial mask writes confirm that bits not written as 1 are left alone. Writes to read-only and unmapped addresses are each followed by read-back.

A random phase mixes sparse set vectors with accesses to every offset and frame word. Each cycle is compared against a behavioural model, which separates lane and offset decoding faults from faults in the update rules.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;
  localparam int WORD_W    = 32;
  localparam int WADDR_W   = 10;
  localparam int WIN_IDX_W = 7;
  localparam int SLOT_W    = 3;
  localparam int CMB_WORDS = 4;
  localparam int CMB_BITS  = CMB_WORDS * WORD_W;

  // word slot inside a window (byte offset / 4)
  localparam logic [SLOT_W-1:0] SLOT_RAW    = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_MASKED = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_SCLR   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_MASK   = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_MSET   = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_MCLR   = 3'd6;

  // frame-level word addresses
  localparam logic [WADDR_W-1:0] WA_CFG   = 10'h3E0;  // byte 0xF80
  localparam logic [WADDR_W-1:0] WA_INTEN = 10'h3E6;  // byte 0xF98
  localparam logic [7:0]         CMB_PAGE = 8'hFA;    // bytes 0xFA0..0xFAF
  localparam int                 INTEN_CMB_BIT = 2;

  typedef struct packed {
    logic sclr;
    logic mset;
    logic mclr;
  } win_wr_t;

  function automatic logic [WORD_W-1:0] stat_next(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] set_bits,
                                                  input logic [WORD_W-1:0] clr_bits);
    return (cur & ~clr_bits) | set_bits;
  endfunction

  function automatic logic [WORD_W-1:0] mask_next(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] set_bits,
                                                  input logic [WORD_W-1:0] clr_bits);
    return (cur | set_bits) & ~clr_bits;
  endfunction

  function automatic logic [WORD_W-1:0] masked_view(input logic [WORD_W-1:0] stat,
                                                    input logic [WORD_W-1:0] mask);
    return stat & ~mask;
  endfunction
endpackage

// File: rtl/mbx_rx_decode.sv
module mbx_rx_decode
  import mbx_rx_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                     wr_en,
  input  logic [WADDR_W-1:0]       waddr,
  output win_wr_t [NUM_WIN-1:0]    win_wr,
  output logic                     inten_wr,
  output logic                     in_win,
  output logic [WIN_IDX_W-1:0]     win_idx,
  output logic [SLOT_W-1:0]        slot
);
  assign win_idx  = waddr[WADDR_W-1:SLOT_W];
  assign slot     = waddr[SLOT_W-1:0];
  assign in_win   = (win_idx < WIN_IDX_W'(NUM_WIN));
  assign inten_wr = wr_en && (waddr == WA_INTEN);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_dec
    logic hit;
    assign hit = wr_en && (win_idx == WIN_IDX_W'(w));
    assign win_wr[w] = '{sclr: hit && (slot == SLOT_SCLR),
                         mset: hit && (slot == SLOT_MSET),
                         mclr: hit && (slot == SLOT_MCLR)};
  end
endmodule

// File: rtl/mbx_rx_window.sv
module mbx_rx_window
  import mbx_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_i,
  input  win_wr_t           wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] masked_o,
  output logic [WORD_W-1:0] clr_o
);
  logic [WORD_W-1:0] mset_bits, mclr_bits;

  assign clr_o     = wr_i.sclr ? wdata_i : '0;
  assign mset_bits = wr_i.mset ? wdata_i : '0;
  assign mclr_bits = wr_i.mclr ? wdata_i : '0;
  assign masked_o  = masked_view(stat_o, mask_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_o <= '0;
      mask_o <= '1;
    end else begin
      stat_o <= stat_next(stat_o, set_i, clr_o);
      mask_o <= mask_next(mask_o, mset_bits, mclr_bits);
    end
  end
endmodule

// File: rtl/mbx_rx_irq_agg.sv
module mbx_rx_irq_agg
  import mbx_rx_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [NUM_WIN*WORD_W-1:0] masked_i,
  output logic [CMB_BITS-1:0]       cmb_o,
  output logic                      any_o
);
  logic [NUM_WIN-1:0] active;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_act
    assign active[w] = |masked_i[w*WORD_W +: WORD_W];
  end

  for (genvar b = 0; b < CMB_BITS; b++) begin : g_cmb
    if (b < NUM_WIN) begin : g_live
      assign cmb_o[b] = active[b];
    end else begin : g_none
      assign cmb_o[b] = 1'b0;
    end
  end

  assign any_o = |active;
endmodule

// File: rtl/mbx_rx_frame.sv
module mbx_rx_frame
  import mbx_rx_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic                      reg_rd_en,
  input  logic [9:0]                reg_waddr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_WIN*32-1:0]     snd_set_i,
  output logic [NUM_WIN*32-1:0]     snd_clr_o,
  output logic                      irq_o,
  output logic                      comb_irq_o
);
  localparam int FLAT_W = NUM_WIN * WORD_W;

  win_wr_t [NUM_WIN-1:0]  win_wr;
  logic                   inten_wr, in_win;
  logic [WIN_IDX_W-1:0]   win_idx;
  logic [SLOT_W-1:0]      slot;
  logic [FLAT_W-1:0]      stat_flat, mask_flat, masked_flat;
  logic [CMB_BITS-1:0]    cmb_bits;
  logic                   any_active;
  logic                   cmb_en;
  logic [WORD_W-1:0]      rd_val, sel_stat, sel_mask;

  mbx_rx_decode #(.NUM_WIN(NUM_WIN)) dec_i (
    .wr_en    (reg_wr_en),
    .waddr    (reg_waddr),
    .win_wr   (win_wr),
    .inten_wr (inten_wr),
    .in_win   (in_win),
    .win_idx  (win_idx),
    .slot     (slot)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mbx_rx_window win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (snd_set_i[w*WORD_W +: WORD_W]),
      .wr_i     (win_wr[w]),
      .wdata_i  (reg_wdata),
      .stat_o   (stat_flat[w*WORD_W +: WORD_W]),
      .mask_o   (mask_flat[w*WORD_W +: WORD_W]),
      .masked_o (masked_flat[w*WORD_W +: WORD_W]),
      .clr_o    (snd_clr_o[w*WORD_W +: WORD_W])
    );
  end

  mbx_rx_irq_agg #(.NUM_WIN(NUM_WIN)) agg_i (
    .masked_i (masked_flat),
    .cmb_o    (cmb_bits),
    .any_o    (any_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        cmb_en <= 1'b0;
    else if (inten_wr) cmb_en <= reg_wdata[INTEN_CMB_BIT];
  end

  assign irq_o      = any_active;
  assign comb_irq_o = any_active & cmb_en;

  always_comb begin
    sel_stat = '0;
    sel_mask = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_idx == WIN_IDX_W'(w)) begin
        sel_stat = stat_flat[w*WORD_W +: WORD_W];
        sel_mask = mask_flat[w*WORD_W +: WORD_W];
      end
    end
    rd_val = '0;
    if (in_win) begin
      case (slot)
        SLOT_RAW:    rd_val = sel_stat;
        SLOT_MASKED: rd_val = masked_view(sel_stat, sel_mask);
        SLOT_MASK:   rd_val = sel_mask;
        default:     rd_val = '0;
      endcase
    end else if (reg_waddr == WA_CFG) begin
      rd_val = {{(WORD_W-WIN_IDX_W){1'b0}}, WIN_IDX_W'(NUM_WIN)};
    end else if (reg_waddr == WA_INTEN) begin
      rd_val[INTEN_CMB_BIT] = cmb_en;
    end else if (reg_waddr[WADDR_W-1:2] == CMB_PAGE) begin
      rd_val = cmb_bits[{reg_waddr[1:0], 5'b00000} +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/mbx_rx_frame_chk.sv
module mbx_rx_frame_chk #(
  parameter int NUM_WIN = 4,
  parameter int FW      = NUM_WIN * 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [FW-1:0] snd_set_i,
  input logic [FW-1:0] snd_clr_o,
  input logic [FW-1:0] stat_flat,
  input logic [FW-1:0] mask_flat,
  input logic          irq_o,
  input logic          comb_irq_o
);
  // R4: every set pulse lands, even against a clear
  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|snd_set_i) |=> ((stat_flat & $past(snd_set_i)) == $past(snd_set_i)));

  // R4: with no set and no clear the status is held
  assert_stat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_set_i == '0 && snd_clr_o == '0) |=> $stable(stat_flat));

  // R3: cleared bits that were not set again read 0 afterwards
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|snd_clr_o) |=> ((stat_flat & $past(snd_clr_o & ~snd_set_i)) == '0));

  // R3: clear pulses only come from a register write
  assert_clear_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|snd_clr_o) |-> reg_wr_en);

  // R5: without a write the mask never moves
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en) |=> $stable(mask_flat));

  // R7: interrupt tracks the unmasked status held in the windows
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(stat_flat & ~mask_flat)));

  // R9: the gated interrupt never fires alone
  assert_comb_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    comb_irq_o |-> irq_o);
endmodule

bind mbx_rx_frame mbx_rx_frame_chk #(.NUM_WIN(NUM_WIN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .snd_set_i  (snd_set_i),
  .snd_clr_o  (snd_clr_o),
  .stat_flat  (stat_flat),
  .mask_flat  (mask_flat),
  .irq_o      (irq_o),
  .comb_irq_o (comb_irq_o)
);

// File: tb/mbx_rx_frame_tb_top.sv
module mbx_rx_frame_tb_top;
  localparam int NW = 4;
  localparam int FW = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en, reg_rd_en;
  logic [9:0]    reg_waddr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [FW-1:0] snd_set_i, snd_clr_o;
  logic          irq_o, comb_irq_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] m_stat [NW];
  logic [31:0] m_mask [NW];
  logic        m_en;

  always #2 clk = ~clk;

  mbx_rx_frame #(.NUM_WIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snd_set_i(snd_set_i), .snd_clr_o(snd_clr_o), .irq_o(irq_o), .comb_irq_o(comb_irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_any();
    bit r = 1'b0;
    for (int w = 0; w < NW; w++) if ((m_stat[w] & ~m_mask[w]) != 0) r = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    int idx;
    int slot;
    int k;
    logic [31:0] v;
    idx = int'(a[11:5]);
    slot = int'(a[4:2]);
    v = '0;
    if (idx < NW) begin
      case (slot)
        0: v = m_stat[idx];
        1: v = m_stat[idx] & ~m_mask[idx];
        4: v = m_mask[idx];
        default: v = '0;
      endcase
    end else if ({a[11:2], 2'b00} == 12'hF80) begin
      v = NW;
    end else if ({a[11:2], 2'b00} == 12'hF98) begin
      v = m_en ? 32'h4 : 32'h0;
    end else if (a[11:4] == 8'hFA) begin
      k = int'(a[3:2]);
      for (int b = 0; b < 32; b++)
        if (k*32 + b < NW) v[b] = ((m_stat[k*32+b] & ~m_mask[k*32+b]) != 0);
    end
    return v;
  endfunction

  function automatic logic [FW-1:0] lane(input int w, input logic [31:0] v);
    logic [FW-1:0] r = '0;
    r[w*32 +: 32] = v;
    return r;
  endfunction

  // one bus cycle: drive, check clear lanes, advance model, check outputs
  task automatic tick(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] wd, input logic [FW-1:0] setv, input string tag);
    logic [FW-1:0] exp_clr;
    logic [31:0]   exp_rd;
    int idx;
    int slot;
    @(negedge clk);
    reg_wr_en = wr; reg_rd_en = rd; reg_waddr = a[11:2]; reg_wdata = wd; snd_set_i = setv;
    #1;
    idx = int'(a[11:5]);
    slot = int'(a[4:2]);
    exp_clr = '0;
    if (wr && idx < NW && slot == 2) exp_clr[idx*32 +: 32] = wd;
    check(snd_clr_o == exp_clr, {"R3 clear lanes ", tag}, snd_clr_o, exp_clr);
    exp_rd = ref_read(a);
    for (int w = 0; w < NW; w++)
      m_stat[w] = (m_stat[w] & ~exp_clr[w*32 +: 32]) | setv[w*32 +: 32];
    if (wr && idx < NW && slot == 5) m_mask[idx] = m_mask[idx] | wd;
    if (wr && idx < NW && slot == 6) m_mask[idx] = m_mask[idx] & ~wd;
    if (wr && {a[11:2], 2'b00} == 12'hF98) m_en = wd[2];
    @(posedge clk);
    #1;
    if (rd) check(reg_rdata == exp_rd, {"R12 read ", tag}, reg_rdata, exp_rd);
    check(irq_o == ref_any(), {"R7 irq ", tag}, irq_o, ref_any());
    check(comb_irq_o == (ref_any() && m_en), {"R9 gated irq ", tag}, comb_irq_o, ref_any() && m_en);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    tick(1'b1, 1'b0, a, d, '0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    tick(1'b0, 1'b1, a, 32'h0, '0, tag);
  endtask
  task automatic setp(input logic [FW-1:0] v, input string tag);
    tick(1'b0, 1'b0, 12'h0, 32'h0, v, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [FW-1:0] sv;
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_waddr = '0; reg_wdata = '0; snd_set_i = '0;
    for (int w = 0; w < NW; w++) begin m_stat[w] = '0; m_mask[w] = '1; end
    m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 reset state, R10 configuration word
    rd(12'h010, "R6 mask all ones");
    rd(12'h070, "R6 last window mask");
    rd(12'h000, "R6 status zero");
    rd(12'hF98, "R6 enable zero");
    rd(12'hF80, "R10 window count");
    check(irq_o == 1'b0, "R6 irq low", irq_o, 0);

    // R4/R2 set on a masked window: raw visible, masked view silent
    setp(lane(2, 32'h0000_0081), "R4 set masked");
    rd(12'h040, "R1 R4 raw window2");
    rd(12'h044, "R2 masked view while masked");
    // R5 unmask partially
    wr(12'h058, 32'h0000_0001, "R5 mask clear bit0");
    rd(12'h050, "R5 mask after clear");
    rd(12'h044, "R2 masked view partial");
    rd(12'hFA0, "R8 combined word0");
    rd(12'hFA4, "R8 combined word1 empty");
    // R9 enable
    wr(12'hF98, 32'hFFFF_FFFF, "R9 enable write");
    rd(12'hF98, "R9 enable readback");
    // R3 partial and full clear
    wr(12'h048, 32'h0000_0080, "R3 clear masked bit");
    rd(12'h040, "R3 raw after partial clear");
    wr(12'h048, 32'h0000_0001, "R3 clear last unmasked");
    rd(12'hFA0, "R8 combined after clear");
    // R4 set and clear same bit same cycle
    wr(12'h058, 32'hFFFF_FFFF, "R5 unmask window2");
    tick(1'b1, 1'b0, 12'h048, 32'h0000_0010, lane(2, 32'h0000_0010), "R4 set wins");
    rd(12'h040, "R4 bit kept");
    setp('0, "R4 hold");
    rd(12'h040, "R4 still held");
    // R5 re-mask silences the interrupt
    wr(12'h054, 32'h0000_0010, "R5 mask set");
    rd(12'h050, "R5 mask after set");
    wr(12'h054, 32'hFFFF_FFEF, "R5 mask set rest");
    rd(12'h050, "R5 mask full");
    // R11 writes to read-only and unmapped locations
    setp(lane(1, 32'h5A5A_0000), "R11 prime window1");
    wr(12'h020, 32'hFFFF_FFFF, "R11 write raw");
    wr(12'h024, 32'hFFFF_FFFF, "R11 write masked view");
    wr(12'h030, 32'h0000_0000, "R11 write mask direct");
    wr(12'h02C, 32'hFFFF_FFFF, "R11 write hole 0x0C");
    wr(12'h03C, 32'h0000_0000, "R11 write hole 0x1C");
    wr(12'hF80, 32'h0000_0000, "R11 write config");
    wr(12'hFA0, 32'hFFFF_FFFF, "R11 write combined");
    wr(12'h200, 32'hFFFF_FFFF, "R11 write unmapped");
    rd(12'h020, "R11 raw unchanged");
    rd(12'h030, "R11 mask unchanged");
    rd(12'hF80, "R11 config unchanged");
    rd(12'h028, "R11 clear alias reads zero");
    rd(12'h034, "R11 set alias reads zero");
    rd(12'h200, "R11 unmapped reads zero");
    wr(12'h028, 32'hFFFF_FFFF, "R3 clean window1");
    wr(12'h048, 32'hFFFF_FFFF, "R3 clean window2");

    // R7 multi-word message: only window 2 unmasked
    wr(12'h058, 32'hFFFF_FFFF, "R7 unmask last");
    setp(lane(0, 32'h1111_1111), "R7 word0 silent");
    setp(lane(1, 32'h2222_2222), "R7 word1 silent");
    setp(lane(2, 32'h3333_3333), "R7 final word fires");
    rd(12'h000, "R1 window0 raw");
    rd(12'h020, "R1 window1 raw");
    rd(12'hFA0, "R8 only last active");
    // R1 stride on the last window
    setp(lane(3, 32'h8000_0000), "R1 set window3");
    rd(12'h060, "R1 window3 raw");
    wr(12'h078, 32'h8000_0000, "R8 unmask window3");
    rd(12'hFA0, "R8 two windows active");
    rd(12'h064, "R2 window3 masked");

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int sel;
      int w;
      sel = int'($urandom % 10);
      w = int'($urandom % NW);
      case ($urandom % 6)
        0: a = 12'(w * 32) + 12'h00;
        1: a = 12'(w * 32) + 12'h04;
        2: a = 12'(w * 32) + 12'h08;
        3: a = 12'(w * 32) + 12'h10;
        4: a = 12'(w * 32) + 12'h14;
        default: a = 12'(w * 32) + 12'h18;
      endcase
      if (sel == 0) a = 12'hF98;
      if (sel == 1) a = 12'hFA0;
      if (sel == 2) a = 12'hF80;
      sv = '0;
      for (int k = 0; k < NW; k++)
        if ($urandom % 3 == 0) sv[k*32 +: 32] = $urandom & $urandom & $urandom;
      tick(1'($urandom % 2), 1'($urandom % 2), a, $urandom & $urandom, sv, "R4 R5 random mix");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule